// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Sender

This block is the command side of a per-processor interrupt controller. Software builds an inter-processor message in two 32-bit registers of a small register window. The high word holds the target processor number. The low word holds the vector, delivery mode, trigger mode, level flag and destination shorthand.

Only a write to the low word sends anything. That write captures the whole message, including the destination currently held in the high word, and presents it on a valid/ready outbound port. A busy bit in the low word reads as one until the outbound side takes the message. Software polls this bit before it issues the next command. A low-word write that arrives while a message is still pending is dropped, and a sticky error flag records that it happened.

Reads are registered: read data appears one clock after the address is presented. For a start-up message, software places the target's start page number in the vector field. The page number is the physical start address divided by 4096.

Top module: `ipi_cmd_sender`

## Requirements
- R1: After reset, msg_valid is 0 and both the low word (offset 0x300) and the high word (offset 0x310) read back as zero.
- R2: A bus write to offset 0x300 while no message is pending raises msg_valid on the next clock. The message carries: vector from bits 7:0, delivery mode from bits 10:8, trigger mode from bit 15, and the destination held in the high word at the time of the write.
- R3: A write to offset 0x310 never raises msg_valid. It only updates the stored destination, which is taken from bits 31:24.
- R4: The 2-bit shorthand in low-word bits 19:18 is passed to msg_shorthand unchanged. The codes are: 0 use the destination field, 1 self only, 2 all including self, 3 all excluding self.
- R5: Low-word bit 14 drives msg_level_assert. A 1 means assert and a 0 means de-assert.
- R6: Low-word readback bit 12 (busy) reads 1 while a message is pending. It reads 0 after a cycle in which msg_valid and msg_ready are both high, and msg_valid falls on that same edge.
- R7: While msg_valid is high and msg_ready is low, msg_valid stays high and every message field stays unchanged.
- R8: A low-word write while a message is pending is ignored: the pending message and its fields are unchanged. The write also sets the sticky error flag, read at low-word bit 13. The flag stays set after the pending message is accepted and clears only on the next accepted low-word write.
- R9: A start-up message delivers the start page number (physical address divided by 4096) unchanged on msg_vector.
- R10: Readback of the low word returns the stored vector, delivery mode, level, trigger and shorthand fields at their write positions, plus busy and error. Readback of the high word returns only bits 31:24. All other bits, and all other offsets, read as zero. Writes to other offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| msg_valid | output | 1 | Outbound message pending |
| msg_ready | input | 1 | Outbound side accepts the message |
| msg_dest | output | 8 | Target processor number |
| msg_shorthand | output | 2 | Destination shorthand code |
| msg_trig_level | output | 1 | Trigger mode, 1 = level |
| msg_level_assert | output | 1 | 1 = assert, 0 = de-assert |
| msg_deliv_mode | output | 3 | Delivery mode |
| msg_vector | output | 8 | Vector or start page number |

## Verification
A fixed-destination send is run with msg_ready held low for several cycles. This separates a correctly held message from one that drops early or whose fields drift. All four shorthand codes are sent, and both level values are sent, so that swapped or mis-positioned fields show up on the outbound port and in readback. A second low-word write during a pending message shows whether the design overwrites the message, launches twice, or fails to latch and later clear the error flag. Writes to the high word and to unrelated offsets show whether anything besides a low-word write can launch a message.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int VEC_W    = 8;
  localparam int DMODE_W  = 3;
  localparam int DEST_W   = 8;
  localparam int SH_W     = 2;

  localparam int VEC_LSB   = 0;
  localparam int DMODE_LSB = 8;
  localparam int BUSY_BIT  = 12;
  localparam int ERR_BIT   = 13;
  localparam int LVL_BIT   = 14;
  localparam int TRIG_BIT  = 15;
  localparam int SH_LSB    = 18;
  localparam int DEST_LSB  = 24;

  typedef enum logic [SH_W-1:0] {
    SH_NONE    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL_INC = 2'd2,
    SH_ALL_EXC = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [DEST_W-1:0]  dest;
    shorthand_e         sh;
    logic               trig_level;
    logic               lvl_assert;
    logic [DMODE_W-1:0] dmode;
    logic [VEC_W-1:0]   vector;
  } ipi_msg_t;

  function automatic ipi_msg_t unpack_low(input logic [WORD_W-1:0] w,
                                          input logic [DEST_W-1:0] d);
    ipi_msg_t m;
    m.dest       = d;
    m.sh         = shorthand_e'(w[SH_LSB +: SH_W]);
    m.trig_level = w[TRIG_BIT];
    m.lvl_assert = w[LVL_BIT];
    m.dmode      = w[DMODE_LSB +: DMODE_W];
    m.vector     = w[VEC_LSB +: VEC_W];
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] pack_low(input ipi_msg_t m,
                                                 input logic busy,
                                                 input logic err);
    logic [WORD_W-1:0] w;
    w = '0;
    w[VEC_LSB +: VEC_W]     = m.vector;
    w[DMODE_LSB +: DMODE_W] = m.dmode;
    w[BUSY_BIT]             = busy;
    w[ERR_BIT]              = err;
    w[LVL_BIT]              = m.lvl_assert;
    w[TRIG_BIT]             = m.trig_level;
    w[SH_LSB +: SH_W]       = m.sh;
    return w;
  endfunction
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_cmd_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              busy,
  input  logic              err,
  input  ipi_msg_t          cur_msg,
  output logic              lo_hit,
  output logic [DEST_W-1:0] dest_q,
  output logic [WORD_W-1:0] rdata
);
  logic hi_hit;

  assign lo_hit = wr_en && (addr == LO_OFS);
  assign hi_hit = wr_en && (addr == HI_OFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q <= '0;
    end else if (hi_hit) begin
      dest_q <= wdata[DEST_LSB +: DEST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == LO_OFS) begin
        rdata <= pack_low(cur_msg, busy, err);
      end else if (addr == HI_OFS) begin
        rdata[DEST_LSB +: DEST_W] <= dest_q;
      end
    end
  end
endmodule

// File: rtl/ipi_msg_launch.sv
module ipi_msg_launch
  import ipi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_hit,
  input  logic [WORD_W-1:0] wdata,
  input  logic [DEST_W-1:0] dest,
  input  logic              out_ready,
  output logic              pending,
  output logic              err,
  output ipi_msg_t          msg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      err     <= 1'b0;
      msg     <= '0;
    end else if (lo_hit && !pending) begin
      pending <= 1'b1;
      err     <= 1'b0;
      msg     <= unpack_low(wdata, dest);
    end else begin
      if (lo_hit) begin
        err <= 1'b1;
      end
      if (pending && out_ready) begin
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ipi_cmd_sender.sv
module ipi_cmd_sender
  import ipi_cmd_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h310
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [1:0]        msg_shorthand,
  output logic              msg_trig_level,
  output logic              msg_level_assert,
  output logic [2:0]        msg_deliv_mode,
  output logic [7:0]        msg_vector
);
  logic              lo_hit;
  logic [DEST_W-1:0] dest_q;
  logic              pending;
  logic              err;
  ipi_msg_t          cur_msg;

  ipi_cmd_regs #(
    .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr_en(bus_wr_en),
    .wdata(bus_wdata), .busy(pending), .err(err), .cur_msg(cur_msg),
    .lo_hit(lo_hit), .dest_q(dest_q), .rdata(bus_rdata)
  );

  ipi_msg_launch u_launch (
    .clk(clk), .rst(rst), .lo_hit(lo_hit), .wdata(bus_wdata),
    .dest(dest_q), .out_ready(msg_ready), .pending(pending),
    .err(err), .msg(cur_msg)
  );

  assign msg_valid        = pending;
  assign msg_dest         = cur_msg.dest;
  assign msg_shorthand    = cur_msg.sh;
  assign msg_trig_level   = cur_msg.trig_level;
  assign msg_level_assert = cur_msg.lvl_assert;
  assign msg_deliv_mode   = cur_msg.dmode;
  assign msg_vector       = cur_msg.vector;
endmodule

// File: rtl/ipi_cmd_sender_chk.sv
module ipi_cmd_sender_chk #(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h300,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h310
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_dest,
  input logic [1:0]        msg_shorthand,
  input logic              msg_trig_level,
  input logic              msg_level_assert,
  input logic [2:0]        msg_deliv_mode,
  input logic [7:0]        msg_vector
);
  logic [22:0] payload;
  logic        lo_wr;
  logic        hi_wr;

  assign payload = {msg_dest, msg_shorthand, msg_trig_level,
                    msg_level_assert, msg_deliv_mode, msg_vector};
  assign lo_wr = bus_wr_en && (bus_addr == LO_OFS);
  assign hi_wr = bus_wr_en && (bus_addr == HI_OFS);

  assert_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (lo_wr && !msg_valid) |=> msg_valid);

  assert_high_no_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (hi_wr && !msg_valid) |=> !msg_valid);

  assert_drop_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> msg_valid);

  assert_payload_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> $stable(payload));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && lo_wr) |=> $stable(payload));
endmodule

bind ipi_cmd_sender ipi_cmd_sender_chk #(
  .ADDR_W(ADDR_W), .LO_OFS(LO_OFS), .HI_OFS(HI_OFS)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
  .msg_shorthand(msg_shorthand), .msg_trig_level(msg_trig_level),
  .msg_level_assert(msg_level_assert), .msg_deliv_mode(msg_deliv_mode),
  .msg_vector(msg_vector)
);

// File: tb/ipi_cmd_sender_tb.sv
module ipi_cmd_sender_tb;
  localparam logic [11:0] LO = 12'h300;
  localparam logic [11:0] HI = 12'h310;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [7:0]  msg_dest;
  logic [1:0]  msg_shorthand;
  logic        msg_trig_level;
  logic        msg_level_assert;
  logic [2:0]  msg_deliv_mode;
  logic [7:0]  msg_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ipi_cmd_sender u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_shorthand(msg_shorthand),
    .msg_trig_level(msg_trig_level), .msg_level_assert(msg_level_assert),
    .msg_deliv_mode(msg_deliv_mode), .msg_vector(msg_vector)
  );

  function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                          input logic lvl, input logic trig,
                                          input logic [1:0] sh);
    return {12'd0, sh, 2'd0, trig, lvl, 2'd0, 1'b0, dm, vec};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R1 valid after reset", 32'(msg_valid), 32'd0);
    bus_read(LO, r); check("R1 low word after reset", r, 32'd0);
    bus_read(HI, r); check("R1 high word after reset", r, 32'd0);
  endtask

  task automatic t_high_write();
    logic [31:0] r;
    bus_write(HI, 32'h5A00_00FF);
    check("R3 high write does not launch", 32'(msg_valid), 32'd0);
    @(negedge clk);
    check("R3 still idle", 32'(msg_valid), 32'd0);
    bus_read(HI, r); check("R10 high readback only 31:24", r, 32'h5A00_0000);
  endtask

  task automatic t_fixed_send();
    logic [31:0] r;
    logic [31:0] w;
    w = lo_word(8'h31, 3'd0, 1'b1, 1'b0, 2'd0);
    bus_write(LO, w);
    check("R2 valid after low write", 32'(msg_valid), 32'd1);
    check("R2 dest", 32'(msg_dest), 32'h5A);
    check("R2 vector", 32'(msg_vector), 32'h31);
    check("R2 delivery mode", 32'(msg_deliv_mode), 32'd0);
    check("R5 level assert", 32'(msg_level_assert), 32'd1);
    bus_read(LO, r); check("R6 busy while pending", r, w | 32'h1000);
    repeat (3) @(negedge clk);
    check("R7 valid held", 32'(msg_valid), 32'd1);
    check("R7 vector held", 32'(msg_vector), 32'h31);
    accept();
    check("R6 valid falls after handshake", 32'(msg_valid), 32'd0);
    bus_read(LO, r); check("R10 low readback idle", r, w);
  endtask

  task automatic t_shorthand();
    for (int i = 0; i < 4; i++) begin
      bus_write(LO, lo_word(8'(8'h40 + i), 3'd0, 1'b1, 1'b0, 2'(i)));
      check("R4 shorthand code", 32'(msg_shorthand), 32'(i));
      accept();
      check("R6 released", 32'(msg_valid), 32'd0);
    end
  endtask

  task automatic t_deassert();
    logic [31:0] r;
    logic [31:0] w;
    w = lo_word(8'h00, 3'd5, 1'b0, 1'b1, 2'd3);
    bus_write(LO, w);
    check("R5 de-assert", 32'(msg_level_assert), 32'd0);
    check("R2 trigger level", 32'(msg_trig_level), 32'd1);
    check("R2 delivery mode 5", 32'(msg_deliv_mode), 32'd5);
    bus_read(LO, r); check("R10 readback trig/sh/dm", r, w | 32'h1000);
    accept();
  endtask

  task automatic t_busy_write();
    logic [31:0] r;
    logic [31:0] a;
    a = lo_word(8'h77, 3'd1, 1'b1, 1'b0, 2'd1);
    bus_write(LO, a);
    bus_write(LO, lo_word(8'h99, 3'd2, 1'b0, 1'b1, 2'd2));
    check("R8 still pending", 32'(msg_valid), 32'd1);
    check("R8 vector unchanged", 32'(msg_vector), 32'h77);
    check("R8 shorthand unchanged", 32'(msg_shorthand), 32'd1);
    bus_read(LO, r); check("R8 error flag set", r, a | 32'h3000);
    accept();
    check("R8 no second launch", 32'(msg_valid), 32'd0);
    bus_read(LO, r); check("R8 error sticky after accept", r, a | 32'h2000);
    bus_write(LO, a);
    bus_read(LO, r); check("R8 error cleared on accepted write", r, a | 32'h1000);
    accept();
  endtask

  task automatic t_startup();
    logic [31:0] pa;
    pa = 32'h0009_A000;
    bus_write(HI, 32'h0300_0000);
    bus_write(LO, lo_word(8'(pa >> 12), 3'd6, 1'b0, 1'b0, 2'd0));
    check("R9 start page on vector", 32'(msg_vector), 32'h9A);
    check("R9 start-up dest", 32'(msg_dest), 32'h03);
    accept();
  endtask

  task automatic t_other_addr();
    logic [31:0] r;
    bus_write(12'h320, 32'hFFFF_FFFF);
    check("R10 other offset no launch", 32'(msg_valid), 32'd0);
    bus_read(12'h320, r); check("R10 other offset reads zero", r, 32'd0);
    bus_read(HI, r); check("R10 high unchanged", r, 32'h0300_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high_write();
    t_fixed_send();
    t_shorthand();
    t_deassert();
    t_busy_write();
    t_startup();
    t_other_addr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule